// File: doc/BRIEF.md
# Message-Signalled Interrupt Write Decoder

This block turns posted memory writes into interrupt pulses. A write-only slave port receives address, data and byte strobes under a valid/ready handshake. Any write whose address falls inside a 64 KiB window at a configurable base is decoded. The slot number, which is the window offset divided by 8, picks an interrupt line. The write payload plays no part in that choice. The chosen line pulses high for one clock, and a downstream edge-sensitive interrupt controller latches it.

The managed range is given by a first and a last line number. The usable count is their difference, so by default lines 96 through 158 are driven, one per slot from 0 to 62. The unit holds no pending state, so software only acknowledges the downstream controller.

A write to a slot past the usable count raises nothing and sets a sticky error flag. The topmost slot of the window is reserved for clearing that flag: software writes a 1 into data bit 0 there, with strobe bit 0 set.

Top module: `msi_write_decoder`

## Requirements
- R1: `wr_ready_o` is 1 in every cycle, including during reset, so every valid write is accepted on the edge where it is presented.
- R2: A write is in the window when address bits [31:16] equal the same bits of `BASE_ADDR`. A write outside the window changes neither `irq_o` nor `oor_err_o`.
- R3: An in-window write to slot k = address[15:3], with k below the line count, drives `irq_o[FIRST_LINE+k]` high for exactly the one cycle after the accepting edge. All other bits stay 0.
- R4: Address bits [2:0] have no effect. Every byte address inside one 8-byte slot selects the same line.
- R5: For interrupt slots, the write data and the byte strobes have no effect on which line pulses, or on whether one pulses.
- R6: The line count is `LAST_LINE - FIRST_LINE` (63 by default). `irq_o` is `LAST_LINE` bits wide, and bits below `FIRST_LINE` are never driven high.
- R7: An in-window write to a slot at or above the line count, other than slot 8191, raises no interrupt. It sets `oor_err_o` on the accepting edge. The flag stays 1 until it is cleared.
- R8: A write to slot 8191 (offset 0xFFF8 to 0xFFFF) with strobe bit 0 = 1 and data bit 0 = 1 clears `oor_err_o`. Any other write to that slot leaves the flag unchanged. No write to that slot raises an interrupt.
- R9: Writes to the same line on back-to-back cycles are not merged: the line is high for one cycle per write. In a cycle after one with no accepted in-range write, `irq_o` is all zero.
- R10: A synchronous active-low reset clears `irq_o` and `oor_err_o` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid_i | input | 1 | Write request valid |
| wr_ready_o | output | 1 | Write ready, tied high |
| wr_addr_i | input | ADDR_W (32) | Byte address of the write |
| wr_data_i | input | DATA_W (32) | Write data; only bit 0 is used, and only in the clear slot |
| wr_strb_i | input | DATA_W/8 (4) | Byte strobes; only bit 0 is used, and only in the clear slot |
| irq_o | output | LAST_LINE (159) | Per-line one-cycle interrupt pulses |
| oor_err_o | output | 1 | Sticky flag for out-of-range writes |

## Verification
The bench aims at the range edges:
- Slot 0 must reach line 96 and slot 62 must reach line 158. An off-by-one in the base offset or in the count comparison would light the neighbouring line, or nothing.
- Slot 63 must set the error flag and raise no line. A design that compared with less-or-equal would fire line 159 instead.

The clear slot is driven with data 0, with the strobe off, and with both set. A design that cleared on any write there, or that treated the slot as out of range, would be caught.

Back-to-back writes to one line must keep it high for two cycles. A design that merged them would show a single pulse.

Writes that reuse a valid slot offset under a different upper address must do nothing. A decoder that skipped the base compare would fire on them.

// File: rtl/msi_pkg.sv
// Package: shared decode result type for the message-signalled interrupt decoder.
// Assumes one write per cycle at most.
package msi_pkg;

    // Decoded action for the write seen in the current cycle
    typedef struct packed {
        logic fire;     // raise the line selected by the slot
        logic set_err;  // out-of-range slot: set the sticky flag
        logic clr_err;  // clear-slot write carrying a 1 in bit 0
    } msi_dec_t;

endpackage

// File: rtl/msi_addr_decode.sv
// Module: msi_addr_decode
// Compares the upper address bits with the window base. Splits the offset
// into an 8-byte slot number and classifies the write as interrupt,
// out-of-range or flag-clear. Purely combinational. Assumes WIN_BITS > 3.
module msi_addr_decode
    import msi_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          WIN_BITS  = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFBE1_0000,
    parameter int          NUM_LINES = 63,
    localparam int         SLOT_W    = WIN_BITS - 3
) (
    input  logic              valid_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              data0_i,
    input  logic              strb0_i,
    output logic [SLOT_W-1:0] slot_o,
    output msi_dec_t          dec_o
);

    logic in_win;
    logic clr_slot;
    logic in_range;

    // Window hit, slot extraction and classification of the write
    always_comb begin
        in_win   = valid_i && (addr_i[ADDR_W-1:WIN_BITS] == BASE_ADDR[ADDR_W-1:WIN_BITS]);
        slot_o   = addr_i[WIN_BITS-1:3];
        clr_slot = &slot_o;
        in_range = (int'(slot_o) < NUM_LINES);
        dec_o.fire    = in_win && in_range;
        dec_o.set_err = in_win && !in_range && !clr_slot;
        dec_o.clr_err = in_win && clr_slot && strb0_i && data0_i;
    end

endmodule

// File: rtl/msi_pulse_gen.sv
// Module: msi_pulse_gen
// One register per managed line. A line goes high for one cycle after the
// edge on which its slot fired. Assumes NUM_LINES fits within the slot space.
module msi_pulse_gen #(
    parameter int  NUM_LINES = 63,
    parameter int  SLOT_W    = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fire_i,
    input  logic [SLOT_W-1:0]    slot_i,
    output logic [NUM_LINES-1:0] pulse_o
);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        // Register this line's pulse for the write accepted on this edge
        always_ff @(posedge clk) begin
            if (!rst_n) pulse_o[i] <= 1'b0;
            else        pulse_o[i] <= fire_i && (slot_i == SLOT_W'(i));
        end
    end

endmodule

// File: rtl/msi_err_flag.sv
// Module: msi_err_flag
// Sticky out-of-range flag. Set wins because set and clear cannot come
// from the same write.
module msi_err_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic err_o
);

    // Hold the flag until an explicit clear
    always_ff @(posedge clk) begin
        if (!rst_n)     err_o <= 1'b0;
        else if (set_i) err_o <= 1'b1;
        else if (clr_i) err_o <= 1'b0;
    end

endmodule

// File: rtl/msi_write_decoder.sv
// Module: msi_write_decoder (top)
// Takes posted writes into a fixed window and emits one-cycle interrupt
// pulses on lines FIRST_LINE .. LAST_LINE-1. Assumes the downstream
// controller latches rising edges.
module msi_write_decoder
    import msi_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          DATA_W     = 32,
    parameter int          WIN_BITS   = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFBE1_0000,
    parameter int          FIRST_LINE = 96,
    parameter int          LAST_LINE  = 159,
    localparam int         STRB_W     = DATA_W / 8,
    localparam int         NUM_LINES  = LAST_LINE - FIRST_LINE,
    localparam int         SLOT_W     = WIN_BITS - 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid_i,
    output logic              wr_ready_o,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [STRB_W-1:0] wr_strb_i,
    output logic [LAST_LINE-1:0] irq_o,
    output logic              oor_err_o
);

    msi_dec_t              dec;
    logic [SLOT_W-1:0]     slot;
    logic [NUM_LINES-1:0]  pulses;
    logic                  unused_bits;

    assign unused_bits = ^{wr_data_i[DATA_W-1:1], wr_strb_i[STRB_W-1:1], wr_addr_i[2:0]};
    assign wr_ready_o  = 1'b1;

    msi_addr_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_BITS (WIN_BITS),
        .BASE_ADDR(BASE_ADDR),
        .NUM_LINES(NUM_LINES)
    ) u_dec (
        .valid_i(wr_valid_i),
        .addr_i (wr_addr_i),
        .data0_i(wr_data_i[0]),
        .strb0_i(wr_strb_i[0]),
        .slot_o (slot),
        .dec_o  (dec)
    );

    msi_pulse_gen #(
        .NUM_LINES(NUM_LINES),
        .SLOT_W   (SLOT_W)
    ) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (dec.fire),
        .slot_i (slot),
        .pulse_o(pulses)
    );

    msi_err_flag u_err (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(dec.set_err),
        .clr_i(dec.clr_err),
        .err_o(oor_err_o)
    );

    assign irq_o[LAST_LINE-1:FIRST_LINE] = pulses;
    if (FIRST_LINE > 0) begin : g_low_zero
        assign irq_o[FIRST_LINE-1:0] = '0;
    end

endmodule

// File: rtl/msi_write_decoder_chk.sv
// Module: msi_write_decoder_chk
// Port-level properties of the decoder. Attached by bind below.
module msi_write_decoder_chk #(
    parameter int          ADDR_W     = 32,
    parameter int          DATA_W     = 32,
    parameter int          WIN_BITS   = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFBE1_0000,
    parameter int          FIRST_LINE = 96,
    parameter int          LAST_LINE  = 159,
    localparam int         STRB_W     = DATA_W / 8,
    localparam int         NUM_LINES  = LAST_LINE - FIRST_LINE,
    localparam int         SLOT_W     = WIN_BITS - 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid_i,
    input logic              wr_ready_o,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic [STRB_W-1:0] wr_strb_i,
    input logic [LAST_LINE-1:0] irq_o,
    input logic              oor_err_o
);

    logic              c_win;
    logic [SLOT_W-1:0] c_slot;
    logic              c_fire, c_oor, c_clear;
    logic [SLOT_W-1:0] prev_slot;
    logic              unused_chk;

    assign unused_chk = ^{wr_data_i, wr_strb_i};

    // Classify the presented write from the ports alone
    always_comb begin
        c_win   = wr_valid_i && (wr_addr_i[ADDR_W-1:WIN_BITS] == BASE_ADDR[ADDR_W-1:WIN_BITS]);
        c_slot  = wr_addr_i[WIN_BITS-1:3];
        c_fire  = c_win && (int'(c_slot) < NUM_LINES);
        c_oor   = c_win && (int'(c_slot) >= NUM_LINES) && !(&c_slot);
        c_clear = c_win && (&c_slot) && wr_strb_i[0] && wr_data_i[0];
    end

    // Remember last cycle's slot for the pulse check
    always_ff @(posedge clk) begin
        prev_slot <= c_slot;
    end

    p_ready_r1: assert property (@(posedge clk) disable iff (!rst_n) wr_ready_o);
    p_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        c_fire |=> irq_o[FIRST_LINE + int'(prev_slot)]);
    p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(irq_o));
    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !c_fire |=> (irq_o == '0));
    p_set_err_r7: assert property (@(posedge clk) disable iff (!rst_n) c_oor |=> oor_err_o);
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (oor_err_o && !c_clear) |=> oor_err_o);
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n) c_clear |=> !oor_err_o);

endmodule

bind msi_write_decoder msi_write_decoder_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .WIN_BITS  (WIN_BITS),
    .BASE_ADDR (BASE_ADDR),
    .FIRST_LINE(FIRST_LINE),
    .LAST_LINE (LAST_LINE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid_i(wr_valid_i),
    .wr_ready_o(wr_ready_o),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .wr_strb_i (wr_strb_i),
    .irq_o     (irq_o),
    .oor_err_o (oor_err_o)
);

// File: tb/msi_write_decoder_tb.sv
// Bench: seeded random writes mixed with directed corners, checked against a
// reference model kept in the bench.
module msi_write_decoder_tb;

    localparam logic [31:0] BASE  = 32'hFBE1_0000;
    localparam int          FIRST = 96;
    localparam int          LAST  = 159;
    localparam int          NLINE = LAST - FIRST;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_valid_i = 1'b0;
    logic              wr_ready_o;
    logic [31:0]       wr_addr_i = '0;
    logic [31:0]       wr_data_i = '0;
    logic [3:0]        wr_strb_i = '0;
    logic [LAST-1:0]   irq_o;
    logic              oor_err_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [LAST-1:0] exp_irq = '0;
    logic            exp_err = 1'b0;
    string           prev_tag = "R10";

    always #10 clk = ~clk;

    msi_write_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .wr_strb_i(wr_strb_i),
        .irq_o(irq_o), .oor_err_o(oor_err_o)
    );

    task automatic check_vec(input logic ok, input string tag, input string what,
                             input logic [LAST-1:0] act, input logic [LAST-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] slot_addr(input int slot, input int low);
        return BASE + 32'(slot * 8 + low);
    endfunction

    // Sample the previous write's results, then present the next write and update the model
    task automatic step(input logic v, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] s, input string tag);
        @(negedge clk);
        check_vec(irq_o === exp_irq, prev_tag, "irq_o", irq_o, exp_irq);
        check_vec(oor_err_o === exp_err, prev_tag, "oor_err_o", LAST'(oor_err_o), LAST'(exp_err));
        check_vec(wr_ready_o === 1'b1, "R1", "wr_ready_o", LAST'(wr_ready_o), LAST'(1));
        wr_valid_i = v; wr_addr_i = a; wr_data_i = d; wr_strb_i = s;
        exp_irq = '0;
        if (v && a[31:16] == BASE[31:16]) begin
            if (int'(a[15:3]) < NLINE) exp_irq[FIRST + int'(a[15:3])] = 1'b1;
            else if (a[15:3] == 13'h1FFF) begin
                if (s[0] && d[0]) exp_err = 1'b0;
            end else exp_err = 1'b1;
        end
        prev_tag = tag;
    endtask

    initial begin
        #(200000 * 20);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R10: outputs clear while held in reset
        check_vec(irq_o === '0, "R10", "irq_o", irq_o, '0);
        check_vec(oor_err_o === 1'b0, "R10", "oor_err_o", LAST'(oor_err_o), '0);
        check_vec(wr_ready_o === 1'b1, "R1", "wr_ready_o in reset", LAST'(wr_ready_o), LAST'(1));
        rst_n = 1'b1;

        step(1, slot_addr(0, 0),  32'h0, 4'h0, "R3");
        step(1, slot_addr(62, 7), 32'hFFFF_FFFF, 4'hF, "R3");
        step(1, slot_addr(10, 5), 32'h1234_5678, 4'h0, "R4");
        step(1, slot_addr(10, 2), 32'h0, 4'hF, "R5");
        step(1, slot_addr(20, 0), 32'hA5A5_A5A5, 4'h3, "R9");
        step(1, slot_addr(20, 4), 32'h0, 4'h0, "R9");
        step(0, slot_addr(20, 0), 32'h0, 4'h0, "R9");
        step(1, {16'h1234, 16'h0040}, 32'h1, 4'h1, "R2");
        step(1, {BASE[31:16] ^ 16'h0001, 16'h1FF8}, 32'h0, 4'h0, "R2");
        step(1, slot_addr(63, 0), 32'h0, 4'h0, "R7");
        step(1, slot_addr(1000, 3), 32'h0, 4'h0, "R7");
        step(1, slot_addr(8191, 0), 32'h0, 4'hF, "R8");
        step(1, slot_addr(8191, 0), 32'h1, 4'h0, "R8");
        step(1, {16'h0000, 16'hFFF8}, 32'h1, 4'h1, "R2");
        step(1, slot_addr(8191, 4), 32'h1, 4'h1, "R8");
        step(1, slot_addr(5, 0), 32'h0, 4'h0, "R6");
        step(1, slot_addr(8191, 0), 32'h1, 4'h1, "R8");

        for (int i = 0; i < 3000; i++) begin
            int    kind = int'($urandom_range(0, 5));
            int    slot;
            logic [31:0] a;
            string tag;
            case (kind)
                0, 1: begin slot = int'($urandom_range(0, NLINE - 1)); tag = "R3"; end
                2:    begin slot = int'($urandom_range(NLINE, 8190));  tag = "R7"; end
                3:    begin slot = 8191;                               tag = "R8"; end
                default: begin slot = int'($urandom_range(0, 8191));   tag = "R5"; end
            endcase
            a = slot_addr(slot, int'($urandom_range(0, 7)));
            if (kind == 5) begin
                a[31:16] = 16'($urandom);
                tag = "R2";
            end
            step(1'($urandom_range(0, 1)), a, $urandom, 4'($urandom), tag);
        end
        step(0, 32'h0, 32'h0, 4'h0, "R9");
        step(0, 32'h0, 32'h0, 4'h0, "R9");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule